// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block keeps the reservation state behind load-exclusive / store-exclusive pairs for a fixed number of requesters. Every requester has its own local tag, which records that it issued a load-exclusive and the word and access size it targeted. A shared global table holds one reservation per requester, and that reservation can be knocked out by writes from the other requesters. A store-exclusive is granted only when both the local tag and the global entry of its requester are still live and match the request. The block then reports a status bit, 0 for performed and 1 for refused, and raises a write-enable toward memory only for a granted store.

One request enters per cycle through a single port. The request carries an operation code, the requester number, the byte address, the access size and the write data. A separate per-requester exception vector drops reservations at any time. Ordinary stores also pass through the same port, so they can invalidate the reservations of other requesters and are forwarded as writes. All outputs are registered, so the response to a request appears on the cycle after it is accepted.

Reservations cover one aligned 32-bit word. The two low address bits take part in the forwarded write address but not in reservation matching.

Top module: `excl_monitor`

## Requirements
- R1: During and right after a synchronous active-high reset, `stx_done`, `stx_status` and `wr_en` are 0 and no requester holds a reservation. A store-exclusive issued as the first request after reset returns status 1 with `wr_en` 0.
- R2: A load-exclusive (op code 0) followed by a store-exclusive (op code 1) from the same requester, to the same word and with the same size, produces `stx_done`=1, `stx_status`=0 and `wr_en`=1 in the next cycle. In that cycle `wr_addr`, `wr_data` and `wr_size` echo the store request.
- R3: A store-exclusive whose size code differs from the reserved size, or whose word address (bits ADDR_W-1..2) differs, returns status 1 with `wr_en` 0. Size codes are 0 for byte, 1 for halfword and 2 for word. Address bits 1..0 are not compared.
- R4: A store-exclusive drops both reservations of its requester, whatever its outcome. A second store-exclusive without a fresh load-exclusive fails.
- R5: Clear-exclusive (op code 2) drops the local tag of its requester only, so that requester's next store-exclusive fails. It does not affect any other requester's reservation and produces no write.
- R6: A high bit i of `exc_event` drops the local tag and the global entry of requester i. If a load-exclusive from requester i arrives in the same cycle, the exception wins.
- R7: An ordinary store (op code 3) always gives `wr_en`=1 with `stx_done`=0 one cycle later. It removes the global entry of every other requester reserving the same word and leaves entries on other words intact.
- R8: A successful store-exclusive removes the global entries of other requesters on the same word. A failed one removes nothing from other requesters.
- R9: Requesters are independent. A load-exclusive by one requester does not change another requester's reservation, and a requester's own ordinary store does not clear its own reservation.
- R10: `stx_done` is high exactly in the cycle after a store-exclusive request and at no other time. Load-exclusive, clear-exclusive and idle cycles produce no write.
- R11: A new load-exclusive from a requester replaces its earlier reserved word and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 load-excl, 1 store-excl, 2 clear-excl, 3 ordinary store |
| req_id | input | ID_W | Issuing requester |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_data | input | DATA_W | Store data |
| exc_event | input | NUM_REQ | Per-requester exception pulse |
| stx_done | output | 1 | Store-exclusive response valid |
| stx_status | output | 1 | 0 performed, 1 refused |
| wr_en | output | 1 | Memory write enable |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | DATA_W | Write data |
| wr_size | output | 2 | Write size code |

## Verification
The assertions take for granted that inputs do not change between clock edges. They also assume that `req_id` stays below NUM_REQ and that no request is offered while reset is high, since responses to such requests are discarded. The stimulus drives every input on the falling clock edge and holds `req_valid` low through reset. Requester numbers are drawn only from the configured range. The randomized phase mixes all four operations over a handful of words and lets two low address bits vary, so that cross-requester invalidation and the same-cycle exception/load-exclusive race occur many times.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic [1:0] {
    OP_LDX   = 2'd0,
    OP_STX   = 2'd1,
    OP_CLRX  = 2'd2,
    OP_STORE = 2'd3
  } excl_op_e;

  localparam int SZ_W = 2;
  localparam logic [SZ_W-1:0] SZ_BYTE = 2'd0;
  localparam logic [SZ_W-1:0] SZ_HALF = 2'd1;
  localparam logic [SZ_W-1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/excl_local_tag.sv
module excl_local_tag #(
  parameter int WA_W = 30,
  parameter int SZ_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic [WA_W-1:0] waddr_i,
  input  logic [SZ_W-1:0] size_i,
  output logic            valid_o,
  output logic [WA_W-1:0] waddr_o,
  output logic [SZ_W-1:0] size_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      waddr_o <= '0;
      size_o  <= '0;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      waddr_o <= waddr_i;
      size_o  <= size_i;
    end
  end

  // R4 / R5 / R6: any clear source empties the tag, even against a set
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !valid_o);

  // R11: a set replaces the recorded word and size
  a_r11_set_records: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> (valid_o && waddr_o == $past(waddr_i) && size_o == $past(size_i)));
endmodule

// File: rtl/excl_global_table.sv
module excl_global_table #(
  parameter int NUM_REQ = 4,
  parameter int WA_W    = 30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] set_i,
  input  logic [NUM_REQ-1:0] clr_own_i,
  input  logic [WA_W-1:0]    set_waddr_i,
  input  logic               inv_en_i,
  input  logic [NUM_REQ-1:0] inv_src_i,
  input  logic [WA_W-1:0]    inv_waddr_i,
  output logic [NUM_REQ-1:0] valid_o,
  output logic [WA_W-1:0]    waddr_o [NUM_REQ]
);
  logic [NUM_REQ-1:0] hit;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_entry
    assign hit[i] = inv_en_i && !inv_src_i[i] && valid_o[i] && (waddr_o[i] == inv_waddr_i);

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_o[i] <= 1'b0;
        waddr_o[i] <= '0;
      end else if (clr_own_i[i] || hit[i]) begin
        valid_o[i] <= 1'b0;
      end else if (set_i[i]) begin
        valid_o[i] <= 1'b1;
        waddr_o[i] <= set_waddr_i;
      end
    end

    // R7 / R8: a foreign write to the reserved word removes the entry
    a_r7_foreign_write_drops: assert property (@(posedge clk) disable iff (rst)
      (inv_en_i && !inv_src_i[i] && valid_o[i] && waddr_o[i] == inv_waddr_i) |=> !valid_o[i]);

    // R5: with no own clear, no hit and no set, the entry holds
    a_r5_entry_holds: assert property (@(posedge clk) disable iff (rst)
      (valid_o[i] && !clr_own_i[i] && !set_i[i] &&
       !(inv_en_i && !inv_src_i[i] && waddr_o[i] == inv_waddr_i))
      |=> (valid_o[i] && waddr_o[i] == $past(waddr_o[i])));
  end
endmodule

// File: rtl/excl_resp_reg.sv
module excl_resp_reg #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SZ_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stx_fire_i,
  input  logic              grant_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SZ_W-1:0]   size_i,
  output logic              stx_done_o,
  output logic              stx_status_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [SZ_W-1:0]   wr_size_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stx_done_o   <= 1'b0;
      stx_status_o <= 1'b0;
      wr_en_o      <= 1'b0;
      wr_addr_o    <= '0;
      wr_data_o    <= '0;
      wr_size_o    <= '0;
    end else begin
      stx_done_o   <= stx_fire_i;
      stx_status_o <= stx_fire_i && !grant_i;
      wr_en_o      <= write_i;
      wr_addr_o    <= addr_i;
      wr_data_o    <= data_i;
      wr_size_o    <= size_i;
    end
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int ID_W    = $clog2(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [1:0]         req_op,
  input  logic [ID_W-1:0]    req_id,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  input  logic [DATA_W-1:0]  req_data,
  input  logic [NUM_REQ-1:0] exc_event,
  output logic               stx_done,
  output logic               stx_status,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic [1:0]         wr_size
);
  localparam int WA_W = ADDR_W - 2;

  excl_op_e           op;
  logic               is_ldx, is_stx, is_clrx, is_store;
  logic [WA_W-1:0]    req_waddr;
  logic [NUM_REQ-1:0] id_hot;
  logic               grant;

  logic [NUM_REQ-1:0] loc_valid;
  logic [WA_W-1:0]    loc_waddr [NUM_REQ];
  logic [SZ_W-1:0]    loc_size  [NUM_REQ];
  logic [NUM_REQ-1:0] glb_valid;
  logic [WA_W-1:0]    glb_waddr [NUM_REQ];

  assign op        = excl_op_e'(req_op);
  assign is_ldx    = req_valid && (op == OP_LDX);
  assign is_stx    = req_valid && (op == OP_STX);
  assign is_clrx   = req_valid && (op == OP_CLRX);
  assign is_store  = req_valid && (op == OP_STORE);
  assign req_waddr = req_addr[ADDR_W-1:2];
  assign id_hot    = req_valid ? (NUM_REQ'(1) << req_id) : '0;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_local
    excl_local_tag #(.WA_W(WA_W), .SZ_W(SZ_W)) u_tag (
      .clk     (clk),
      .rst     (rst),
      .set_i   (is_ldx && id_hot[i]),
      .clr_i   (((is_stx || is_clrx) && id_hot[i]) || exc_event[i]),
      .waddr_i (req_waddr),
      .size_i  (req_size),
      .valid_o (loc_valid[i]),
      .waddr_o (loc_waddr[i]),
      .size_o  (loc_size[i])
    );
  end

  assign grant = is_stx && loc_valid[req_id] && glb_valid[req_id]
              && (loc_waddr[req_id] == req_waddr)
              && (loc_size[req_id]  == req_size)
              && (glb_waddr[req_id] == req_waddr);

  excl_global_table #(.NUM_REQ(NUM_REQ), .WA_W(WA_W)) u_gtab (
    .clk         (clk),
    .rst         (rst),
    .set_i       (is_ldx ? id_hot : '0),
    .clr_own_i   ((is_stx ? id_hot : '0) | exc_event),
    .set_waddr_i (req_waddr),
    .inv_en_i    (is_store || grant),
    .inv_src_i   (id_hot),
    .inv_waddr_i (req_waddr),
    .valid_o     (glb_valid),
    .waddr_o     (glb_waddr)
  );

  excl_resp_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SZ_W(SZ_W)) u_resp (
    .clk          (clk),
    .rst          (rst),
    .stx_fire_i   (is_stx),
    .grant_i      (grant),
    .write_i      (is_store || grant),
    .addr_i       (req_addr),
    .data_i       (req_data),
    .size_i       (req_size),
    .stx_done_o   (stx_done),
    .stx_status_o (stx_status),
    .wr_en_o      (wr_en),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .wr_size_o    (wr_size)
  );

  // R10: response strobe tracks store-exclusive requests one cycle later
  a_r10_done_after_stx: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'd1) |=> stx_done);
  a_r10_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_op == 2'd1) |=> !stx_done);
  // R2: write-enable of a store-exclusive is the inverse of its status
  a_r2_status_gates_write: assert property (@(posedge clk) disable iff (rst)
    stx_done |-> (wr_en == !stx_status));
  // R7: an ordinary store is always forwarded
  a_r7_store_forwarded: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'd3) |=> (wr_en && !stx_done));
  // R1: a requester with no live local tag is never granted
  a_r1_no_grant_untagged: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'd1 && !loc_valid[req_id]) |=> (stx_status && !wr_en));
endmodule

// File: tb/excl_monitor_tb.sv
module excl_monitor_tb;
  localparam int N = 4;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = '0;
  logic [1:0]    req_id = '0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic [DW-1:0] req_data = '0;
  logic [N-1:0]  exc_event = '0;
  logic          stx_done, stx_status, wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [1:0]    wr_size;

  int checks = 0;
  int errors = 0;

  bit            m_lv [N];
  bit            m_gv [N];
  logic [AW-1:0] m_wa [N];
  logic [1:0]    m_sz [N];

  always #10 clk = ~clk;

  excl_monitor #(.NUM_REQ(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_id(req_id),
    .req_addr(req_addr), .req_size(req_size), .req_data(req_data), .exc_event(exc_event),
    .stx_done(stx_done), .stx_status(stx_status), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_size(wr_size)
  );

  initial begin
    #(20 * 50000);
    errors++;
    $display("FAIL watchdog: run did not end");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // one cycle: drive at negedge, predict, compare after the next edge
  task automatic cyc(input bit v, input int op, input int id, input logic [AW-1:0] a,
                     input int sz, input logic [DW-1:0] d, input logic [N-1:0] ex,
                     input string tag);
    bit ok, e_done, e_st, e_we;
    logic [AW-1:0] wa;
    req_valid = v; req_op = 2'(op); req_id = 2'(id); req_addr = a;
    req_size = 2'(sz); req_data = d; exc_event = ex;
    wa = a >> 2;
    e_done = 0; e_st = 0; e_we = 0;
    if (v) begin
      case (op)
        0: begin m_lv[id] = 1; m_gv[id] = 1; m_wa[id] = wa; m_sz[id] = 2'(sz); end
        1: begin
          ok = m_lv[id] && m_gv[id] && m_wa[id] == wa && m_sz[id] == 2'(sz);
          e_done = 1; e_st = !ok; e_we = ok;
          if (ok) for (int j = 0; j < N; j++) if (j != id && m_wa[j] == wa) m_gv[j] = 0;
          m_lv[id] = 0; m_gv[id] = 0;
        end
        2: m_lv[id] = 0;
        default: begin
          e_we = 1;
          for (int j = 0; j < N; j++) if (j != id && m_wa[j] == wa) m_gv[j] = 0;
        end
      endcase
    end
    for (int i = 0; i < N; i++) if (ex[i]) begin m_lv[i] = 0; m_gv[i] = 0; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; exc_event = '0;
    checks++;
    if (stx_done !== e_done || stx_status !== e_st || wr_en !== e_we ||
        (e_we && (wr_addr !== a || wr_data !== d || wr_size !== 2'(sz)))) begin
      errors++;
      $display("FAIL %s: done/st/we=%b%b%b addr=%h data=%h expected %b%b%b addr=%h data=%h",
               tag, stx_done, stx_status, wr_en, wr_addr, wr_data, e_done, e_st, e_we, a, d);
    end
  endtask

  // hand-derived status of the store-exclusive just completed
  task automatic lit(input bit exp_st, input string tag);
    checks++;
    if (stx_done !== 1'b1 || stx_status !== exp_st || wr_en !== !exp_st) begin
      errors++;
      $display("FAIL %s: status=%b we=%b expected status=%b we=%b",
               tag, stx_status, wr_en, exp_st, !exp_st);
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_lv[i] = 0; m_gv[i] = 0; m_wa[i] = '1; m_sz[i] = 0; end
    repeat (3) @(negedge clk);
    checks++;
    if (stx_done !== 0 || stx_status !== 0 || wr_en !== 0) begin
      errors++;
      $display("FAIL R1 in reset: %b%b%b expected 000", stx_done, stx_status, wr_en);
    end
    rst = 0;
    cyc(1, 1, 0, 32'h100, 2, 32'h11, 0, "R1"); lit(1, "R1 stx after reset");
    // R2 basic success
    cyc(1, 0, 0, 32'h100, 2, 0, 0, "R2");
    cyc(1, 1, 0, 32'h100, 2, 32'hCAFE, 0, "R2"); lit(0, "R2 paired success");
    // R4 second store-exclusive fails
    cyc(1, 1, 0, 32'h100, 2, 32'h22, 0, "R4"); lit(1, "R4 reuse refused");
    // R3 mismatches and low bits
    cyc(1, 0, 1, 32'h200, 1, 0, 0, "R3");
    cyc(1, 1, 1, 32'h200, 0, 32'h33, 0, "R3"); lit(1, "R3 size mismatch");
    cyc(1, 0, 1, 32'h200, 1, 0, 0, "R3");
    cyc(1, 1, 1, 32'h204, 1, 32'h34, 0, "R3"); lit(1, "R3 word mismatch");
    cyc(1, 0, 1, 32'h200, 1, 0, 0, "R3");
    cyc(1, 1, 1, 32'h202, 1, 32'h35, 0, "R3"); lit(0, "R3 low bits ignored");
    // R5 clear-exclusive
    cyc(1, 0, 2, 32'h300, 2, 0, 0, "R5");
    cyc(1, 2, 2, 32'h300, 2, 0, 0, "R5");
    cyc(1, 1, 2, 32'h300, 2, 32'h44, 0, "R5"); lit(1, "R5 cleared requester");
    cyc(1, 0, 0, 32'h400, 2, 0, 0, "R5");
    cyc(1, 0, 3, 32'h500, 2, 0, 0, "R5");
    cyc(1, 2, 3, 32'h500, 2, 0, 0, "R5");
    cyc(1, 1, 0, 32'h400, 2, 32'h45, 0, "R5"); lit(0, "R5 other requester kept");
    // R6 exceptions
    cyc(1, 0, 1, 32'h600, 2, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 0, 4'b0010, "R6");
    cyc(1, 1, 1, 32'h600, 2, 32'h55, 0, "R6"); lit(1, "R6 exception drop");
    cyc(1, 0, 2, 32'h700, 2, 0, 4'b0100, "R6");
    cyc(1, 1, 2, 32'h700, 2, 32'h56, 0, "R6"); lit(1, "R6 exception beats set");
    // R7 ordinary stores
    cyc(1, 0, 0, 32'h800, 2, 0, 0, "R7");
    cyc(1, 3, 3, 32'h801, 0, 32'h66, 0, "R7");
    cyc(1, 1, 0, 32'h800, 2, 32'h67, 0, "R7"); lit(1, "R7 foreign store same word");
    cyc(1, 0, 0, 32'h800, 2, 0, 0, "R7");
    cyc(1, 3, 3, 32'h808, 2, 32'h68, 0, "R7");
    cyc(1, 1, 0, 32'h800, 2, 32'h69, 0, "R7"); lit(0, "R7 store other word");
    // R8 store-exclusive invalidation
    cyc(1, 0, 0, 32'h900, 2, 0, 0, "R8");
    cyc(1, 0, 1, 32'h900, 2, 0, 0, "R8");
    cyc(1, 1, 1, 32'h900, 2, 32'h77, 0, "R8"); lit(0, "R8 winner");
    cyc(1, 1, 0, 32'h900, 2, 32'h78, 0, "R8"); lit(1, "R8 loser");
    cyc(1, 0, 0, 32'hA00, 2, 0, 0, "R8");
    cyc(1, 0, 1, 32'hA00, 2, 0, 0, "R8");
    cyc(1, 1, 1, 32'hA00, 0, 32'h79, 0, "R8"); lit(1, "R8 failed stx");
    cyc(1, 1, 0, 32'hA00, 2, 32'h7A, 0, "R8"); lit(0, "R8 failed stx harmless");
    // R9 independence
    cyc(1, 0, 0, 32'hB00, 2, 0, 0, "R9");
    cyc(1, 0, 3, 32'hC00, 1, 0, 0, "R9");
    cyc(1, 3, 0, 32'hB00, 2, 32'h88, 0, "R9");
    cyc(1, 1, 0, 32'hB00, 2, 32'h89, 0, "R9"); lit(0, "R9 own store keeps");
    cyc(1, 1, 3, 32'hC00, 1, 32'h8A, 0, "R9"); lit(0, "R9 other requester intact");
    // R11 replacement
    cyc(1, 0, 2, 32'hD00, 2, 0, 0, "R11");
    cyc(1, 0, 2, 32'hE00, 1, 0, 0, "R11");
    cyc(1, 1, 2, 32'hD00, 2, 32'h99, 0, "R11"); lit(1, "R11 old word gone");
    cyc(1, 0, 2, 32'hD00, 2, 0, 0, "R11");
    cyc(1, 0, 2, 32'hE00, 1, 0, 0, "R11");
    cyc(1, 1, 2, 32'hE00, 1, 32'h9A, 0, "R11"); lit(0, "R11 new word holds");
    // R10 quiet cycles
    for (int k = 0; k < 4; k++) cyc(0, 1, 0, 0, 0, 0, 0, "R10");
    // mixed traffic against the model
    for (int k = 0; k < 3000; k++) begin
      int sel;
      logic [AW-1:0] a;
      sel = int'($urandom % 3);
      a = (sel == 0) ? 32'h1000 : (sel == 1) ? 32'h1004 : 32'h2000;
      a[1:0] = 2'($urandom);
      cyc(($urandom % 8) != 0, int'($urandom % 4), int'($urandom % N), a,
          int'($urandom % 3), $urandom, (($urandom % 10) == 0) ? 4'($urandom) : 4'b0,
          "R8 mixed");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule